// File: doc/BRIEF.md
# Jam-Loaded Reference and Feedback Dividers

This block holds the two programmable dividers of a frequency synthesizer front end, plus a small divider that produces a scaled copy of the reference. The reference counter and the feedback counter both count down. Each moves one step on a rising edge of its own input. Every time a counter reaches the end of its period it raises a short high pulse. Both pulses go to a phase comparator that sits outside this block. A third divider takes the reference edges and scales them by a power of two chosen with a 3-bit select. It provides a reference output for other logic.

When the control logic writes a new feedback divide value, it raises a one-cycle load strobe. The strobe reloads both counters in the same cycle, so they start counting down from an aligned point. This lets the loop settle faster and keeps partly counted data out of the comparator. Each divided pulse output has its own enable bit, and a cleared bit holds that output at a static low.

Both the reference input and the feedback input arrive as one-cycle clock-enable ticks in a single system clock domain. Every output is registered.

Top module: `synth_divider_core`

## Requirements
- R1: While reset is high and on the first cycle after it, `ref_pulse_o`, `fb_pulse_o` and `refout_o` are low.
- R2: For a reference ratio R between 5 and 32767, `ref_pulse_o` rises after the R-th reference tick that follows a load. It rises again every R ticks after that.
- R3: The reference pulse stays high for 5 reference ticks. It falls after the 5th tick that follows its rising tick. When R is 5 the pulse lasts 4 ticks, so the output still returns low once per period.
- R4: With a reference ratio of 1, `ref_pulse_o` is high for exactly the one clock cycle after each reference tick, and low otherwise.
- R5: Reference ratio values 0, 2, 3 and 4 behave exactly like a ratio of 5.
- R6: For a feedback ratio N between 40 and 65535, `fb_pulse_o` rises after the N-th feedback tick that follows a load. It stays high until the next feedback tick.
- R7: Feedback ratio values 0 to 39 behave exactly like a ratio of 40.
- R8: A cycle with `load_strobe` high reloads both counters from their current ratio inputs and ends any pulse that is active. Any tick in that same cycle is ignored. The next pulses therefore come R and N ticks after the load.
- R9: When `ref_pulse_en` or `fb_pulse_en` is low, the matching output is low in the following cycle. The counters keep running while the output is held low.
- R10: `refout_o` is a one-cycle pulse after a reference tick, and its rate follows `refout_sel`:
  - 000 turns the output off.
  - 001 gives divide by 1.
  - 010 gives divide by 2.
  - 011 gives divide by 4.
  - 100 and 110 give divide by 8.
  - 101 and 111 give divide by 16.
  
  Counting from reset, pulses follow the k-th, 2k-th, 3k-th and later ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle marker for a reference rising edge |
| fb_tick | input | 1 | One-cycle marker for a feedback rising edge |
| load_strobe | input | 1 | Reloads both counters when a new feedback ratio is written |
| ref_ratio | input | 15 | Reference divide ratio |
| fb_ratio | input | 16 | Feedback divide ratio |
| ref_pulse_en | input | 1 | Enable for the reference pulse output |
| fb_pulse_en | input | 1 | Enable for the feedback pulse output |
| refout_sel | input | 3 | Select code for the scaled reference output |
| ref_pulse_o | output | 1 | Divided reference pulse |
| fb_pulse_o | output | 1 | Divided feedback pulse |
| refout_o | output | 1 | Scaled reference output |

## Verification
The bench targets the period boundary of both counters. If a counter reloads off by one, it produces pulses at R±1 ticks; the bench compares the output after every single tick, so that shows up as a mismatch. For a ratio of exactly 5, the bench checks that the pulse drops for one tick. A design that kept the full width would never let the output fall. The bench also checks that values 0, 2, 3, 4 and values below 40 are clamped, so a design that divided by the raw value would fall out of step. It loads while both counters are part-way through a period and with ticks arriving in the same cycle; a design that kept the old count or counted the coincident tick would pulse one tick early. The bench checks every reference-output select code, including the repeated codes 110 and 111.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  localparam int SEL_W     = 3;
  localparam int SHIFT_MAX = 4;

  typedef struct packed {
    logic       on;
    logic [2:0] shift;
  } refout_cfg_t;

  function automatic refout_cfg_t decode_refout(input logic [SEL_W-1:0] sel);
    refout_cfg_t c;
    c.on = (sel != '0);
    unique case (sel)
      3'd1:    c.shift = 3'd0;
      3'd2:    c.shift = 3'd1;
      3'd3:    c.shift = 3'd2;
      3'd4,
      3'd6:    c.shift = 3'd3;
      3'd5,
      3'd7:    c.shift = 3'd4;
      default: c.shift = 3'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int W           = 15,
  parameter int MIN_RATIO   = 5,
  parameter int PULSE_TICKS = 5,
  parameter bit ALLOW_ONE   = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         jam,
  input  logic [W-1:0] ratio,
  input  logic         en,
  output logic         pulse_o
);

  localparam int            PW_W  = $clog2(PULSE_TICKS + 1);
  localparam logic [W-1:0]  MIN_V = W'(MIN_RATIO);
  localparam logic [W-1:0]  PT_W  = W'(PULSE_TICKS);
  localparam logic [W-1:0]  ONE   = W'(1);

  logic [W-1:0]    cnt, cnt_n;
  logic [PW_W-1:0] pw, pw_n;
  logic [W-1:0]    eff, eff_m1;
  logic [PW_W-1:0] plen;
  logic            bypass;
  logic            hit;
  logic            pulse_q;

  generate
    if (ALLOW_ONE) begin : g_bypass
      assign bypass = (ratio == ONE);
    end else begin : g_no_bypass
      assign bypass = 1'b0;
    end
  endgenerate

  // clamp illegal ratios up to the smallest legal value
  assign eff    = (ratio < MIN_V) ? MIN_V : ratio;
  assign eff_m1 = eff - ONE;
  assign plen   = (eff_m1 < PT_W) ? eff_m1[PW_W-1:0] : PW_W'(PULSE_TICKS);

  always_comb begin
    cnt_n = cnt;
    pw_n  = pw;
    if (jam) begin
      cnt_n = eff;
      pw_n  = '0;
    end else if (tick) begin
      if (cnt <= ONE) begin
        cnt_n = eff;
        pw_n  = plen;
      end else begin
        cnt_n = cnt - ONE;
        if (pw != '0) pw_n = pw - PW_W'(1);
      end
    end
  end

  assign hit = bypass ? (tick && !jam) : (pw_n != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= eff;
      pw      <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      pw      <= pw_n;
      pulse_q <= en && hit;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/refout_divider.sv
module refout_divider
  import synth_div_pkg::*;
#(
  parameter int CNT_W = SHIFT_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             out_o
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  refout_cfg_t      cfg;
  logic             match;
  logic             out_q;

  assign cfg   = decode_refout(sel);
  assign mask  = CNT_W'((1 << cfg.shift) - 1);
  assign match = ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + CNT_W'(1);
      out_q <= tick && cfg.on && match;
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/synth_divider_core.sv
module synth_divider_core
  import synth_div_pkg::*;
#(
  parameter int REF_W       = 15,
  parameter int FB_W        = 16,
  parameter int REF_MIN     = 5,
  parameter int FB_MIN      = 40,
  parameter int REF_PULSE   = 5,
  parameter int FB_PULSE    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             fb_tick,
  input  logic             load_strobe,
  input  logic [REF_W-1:0] ref_ratio,
  input  logic [FB_W-1:0]  fb_ratio,
  input  logic             ref_pulse_en,
  input  logic             fb_pulse_en,
  input  logic [SEL_W-1:0] refout_sel,
  output logic             ref_pulse_o,
  output logic             fb_pulse_o,
  output logic             refout_o
);

  tick_divider #(
    .W(REF_W), .MIN_RATIO(REF_MIN), .PULSE_TICKS(REF_PULSE), .ALLOW_ONE(1'b1)
  ) i_ref_div (
    .clk(clk), .rst(rst), .tick(ref_tick), .jam(load_strobe),
    .ratio(ref_ratio), .en(ref_pulse_en), .pulse_o(ref_pulse_o)
  );

  tick_divider #(
    .W(FB_W), .MIN_RATIO(FB_MIN), .PULSE_TICKS(FB_PULSE), .ALLOW_ONE(1'b0)
  ) i_fb_div (
    .clk(clk), .rst(rst), .tick(fb_tick), .jam(load_strobe),
    .ratio(fb_ratio), .en(fb_pulse_en), .pulse_o(fb_pulse_o)
  );

  refout_divider #(.CNT_W(SHIFT_MAX)) i_refout (
    .clk(clk), .rst(rst), .tick(ref_tick), .sel(refout_sel), .out_o(refout_o)
  );

endmodule

// File: rtl/synth_div_checker.sv
module synth_div_checker #(
  parameter int REF_W = 15,
  parameter int FB_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_tick,
  input logic             fb_tick,
  input logic             load_strobe,
  input logic [REF_W-1:0] ref_ratio,
  input logic             ref_pulse_en,
  input logic             fb_pulse_en,
  input logic [2:0]       refout_sel,
  input logic             ref_pulse_o,
  input logic             fb_pulse_o,
  input logic             refout_o
);

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!ref_pulse_o && !fb_pulse_o && !refout_o));

  a_r9_ref_gate: assert property (@(posedge clk) disable iff (rst)
    !ref_pulse_en |=> !ref_pulse_o);

  a_r9_fb_gate: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse_en |=> !fb_pulse_o);

  a_r8_load_clears: assert property (@(posedge clk) disable iff (rst)
    load_strobe |=> (!ref_pulse_o && !fb_pulse_o));

  a_r4_bypass_follows: assert property (@(posedge clk) disable iff (rst)
    (ref_ratio == REF_W'(1) && ref_pulse_en && ref_tick && !load_strobe)
      |=> ref_pulse_o);

  a_r6_fb_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!fb_tick && !load_strobe && fb_pulse_en && $past(fb_pulse_en))
      |=> (fb_pulse_o == $past(fb_pulse_o)));

  a_r10_off_low: assert property (@(posedge clk) disable iff (rst)
    (refout_sel == 3'd0) |=> !refout_o);

  a_r10_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> !refout_o);

endmodule

bind synth_divider_core synth_div_checker #(.REF_W(REF_W), .FB_W(FB_W)) i_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
  .load_strobe(load_strobe), .ref_ratio(ref_ratio),
  .ref_pulse_en(ref_pulse_en), .fb_pulse_en(fb_pulse_en),
  .refout_sel(refout_sel), .ref_pulse_o(ref_pulse_o),
  .fb_pulse_o(fb_pulse_o), .refout_o(refout_o)
);

// File: tb/test_synth_divider_core.sv
`timescale 1ns/1ps
module test_synth_divider_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0, fb_tick = 1'b0, load_strobe = 1'b0;
  logic [14:0] ref_ratio = 15'd7;
  logic [15:0] fb_ratio = 16'd40;
  logic        ref_pulse_en = 1'b0, fb_pulse_en = 1'b0;
  logic [2:0]  refout_sel = 3'd0;
  logic        ref_pulse_o, fb_pulse_o, refout_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  synth_divider_core i_synth_divider_core (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .load_strobe(load_strobe), .ref_ratio(ref_ratio), .fb_ratio(fb_ratio),
    .ref_pulse_en(ref_pulse_en), .fb_pulse_en(fb_pulse_en),
    .refout_sel(refout_sel), .ref_pulse_o(ref_pulse_o),
    .fb_pulse_o(fb_pulse_o), .refout_o(refout_o)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_model(input int k, input int r);
    int w;
    w = (r - 1 < 5) ? r - 1 : 5;
    if (k < r) return 1'b0;
    return ((k % r) < w);
  endfunction

  function automatic bit fb_model(input int k, input int n);
    return (k >= n) && ((k % n) == 0);
  endfunction

  task automatic step_ref();
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
  endtask

  task automatic step_fb();
    @(negedge clk) fb_tick = 1'b1;
    @(negedge clk) fb_tick = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk) load_strobe = 1'b1;
    @(negedge clk) load_strobe = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check(ref_pulse_o, 1'b0, "R1 ref low in reset");
    check(fb_pulse_o, 1'b0, "R1 fb low in reset");
    check(refout_o, 1'b0, "R1 refout low in reset");
    rst = 1'b0;
    @(negedge clk);
    check(ref_pulse_o | fb_pulse_o | refout_o, 1'b0, "R1 outputs low after reset");
  endtask

  task automatic t_ref_run(input int ratio_in, input int model_r, input int n, input string tag);
    ref_ratio = 15'(ratio_in);
    ref_pulse_en = 1'b1;
    do_load();
    for (int k = 1; k <= n; k++) begin
      step_ref();
      check(ref_pulse_o, ref_model(k, model_r), tag);
    end
  endtask

  task automatic t_ref_bypass();
    ref_ratio = 15'd1;
    ref_pulse_en = 1'b1;
    do_load();
    for (int k = 0; k < 4; k++) begin
      step_ref();
      check(ref_pulse_o, 1'b1, "R4 bypass high after tick");
      @(negedge clk);
      check(ref_pulse_o, 1'b0, "R4 bypass low without tick");
    end
  endtask

  task automatic t_fb_run(input int ratio_in, input int model_n, input int n, input string tag);
    fb_ratio = 16'(ratio_in);
    fb_pulse_en = 1'b1;
    do_load();
    for (int k = 1; k <= n; k++) begin
      step_fb();
      check(fb_pulse_o, fb_model(k, model_n), tag);
    end
  endtask

  task automatic t_load_align();
    ref_ratio = 15'd6;
    fb_ratio  = 16'd40;
    ref_pulse_en = 1'b1;
    fb_pulse_en  = 1'b1;
    do_load();
    for (int k = 0; k < 6; k++) step_ref();
    for (int k = 0; k < 17; k++) step_fb();
    check(ref_pulse_o, 1'b1, "R8 ref pulse active before load");
    // load with ticks in the same cycle: ticks ignored, pulse cleared
    @(negedge clk) begin load_strobe = 1'b1; ref_tick = 1'b1; fb_tick = 1'b1; end
    @(negedge clk) begin load_strobe = 1'b0; ref_tick = 1'b0; fb_tick = 1'b0; end
    check(ref_pulse_o, 1'b0, "R8 load ends ref pulse");
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk) begin ref_tick = 1'b1; fb_tick = 1'b1; end
      @(negedge clk) begin ref_tick = 1'b0; fb_tick = 1'b0; end
      check(ref_pulse_o, ref_model(k, 6), "R8 ref restarts aligned");
      check(fb_pulse_o, fb_model(k, 40), "R8 fb restarts aligned");
    end
  endtask

  task automatic t_enable();
    ref_ratio = 15'd7;
    ref_pulse_en = 1'b0;
    do_load();
    for (int k = 1; k <= 7; k++) begin
      step_ref();
      check(ref_pulse_o, 1'b0, "R9 ref held low when disabled");
    end
    @(negedge clk) ref_pulse_en = 1'b1;
    @(negedge clk);
    check(ref_pulse_o, 1'b1, "R9 counter kept running while disabled");
    fb_ratio = 16'd40;
    fb_pulse_en = 1'b0;
    do_load();
    for (int k = 1; k <= 40; k++) step_fb();
    check(fb_pulse_o, 1'b0, "R9 fb held low when disabled");
    fb_pulse_en = 1'b1;
  endtask

  task automatic t_refout();
    int divs[8] = '{0, 1, 2, 4, 8, 16, 8, 16};
    do_reset();
    for (int s = 0; s < 8; s++) begin
      int cnt;
      cnt = 0;
      refout_sel = 3'(s);
      for (int j = 1; j <= 16; j++) begin
        bit exp;
        exp = (divs[s] != 0) && ((j % ((divs[s] != 0) ? divs[s] : 1)) == 0);
        step_ref();
        check(refout_o, exp, "R10 refout after tick");
        if (refout_o) cnt++;
        @(negedge clk);
        check(refout_o, 1'b0, "R10 refout single cycle");
      end
      total++;
      if (cnt != ((divs[s] != 0) ? 16 / divs[s] : 0)) begin
        bad++;
        $display("FAIL R10 pulse count sel=%0d: actual=%0d expected=%0d", s, cnt,
                 (divs[s] != 0) ? 16 / divs[s] : 0);
      end
    end
    refout_sel = 3'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_ref_run(7, 7, 21, "R2 R3 ref ratio 7");
    t_ref_run(12, 12, 36, "R2 R3 ref ratio 12");
    t_ref_run(5, 5, 15, "R3 ref ratio 5 width 4");
    t_ref_run(0, 5, 10, "R5 ref ratio 0 acts as 5");
    t_ref_run(2, 5, 10, "R5 ref ratio 2 acts as 5");
    t_ref_run(3, 5, 10, "R5 ref ratio 3 acts as 5");
    t_ref_run(4, 5, 10, "R5 ref ratio 4 acts as 5");
    t_ref_bypass();
    t_fb_run(45, 45, 90, "R6 fb ratio 45");
    t_fb_run(40, 40, 80, "R6 fb ratio 40");
    t_fb_run(3, 40, 80, "R7 fb ratio 3 acts as 40");
    t_fb_run(0, 40, 41, "R7 fb ratio 0 acts as 40");
    t_load_align();
    t_enable();
    t_refout();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule